// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Sweep Invalidation

This block is a small fully associative translation cache. Each entry records a virtual page number, a physical frame number, an address-space ID, a process-context ID and a root tag. The root tag is bits 51:12 of the nested page-table root pointer under which the translation was built. A lookup hits only when all four tag fields match a valid entry. A fill installs a translation. Both share one ready signal, and a lookup's result is returned from a register one cycle after it is accepted.

Software-style invalidation commands carry a type value, a mode flag that selects a 64-bit or 32-bit type value, a 128-bit descriptor and a two-bit capability vector. Before any state changes, a command is checked:

- Type 1 (single-context) needs capability bit 0 and clears entries whose root tag equals descriptor bits 51:12.
- Type 2 (global) needs capability bit 1 and clears every entry.
- Descriptor bits 127:64 are reserved and must be zero.

Matching ignores the address-space and process-context tags. An accepted command sweeps the entries in index order, one per cycle, and ends with a done pulse. A rejected command raises a fail pulse and touches nothing.

The controller has four states:

- `ST_IDLE`: ready is high and commands are accepted.
- `ST_SWEEP`: the entries are visited.
- `ST_DONE`: the done pulse is raised.
- `ST_REJECT`: the fail pulse is raised.

The transitions are as follows:

- `ST_IDLE` goes to `ST_SWEEP` on a valid command that passes the check.
- `ST_IDLE` goes to `ST_REJECT` on a valid command that fails the check.
- `ST_SWEEP` goes to `ST_DONE` after the last entry has been visited.
- `ST_DONE` returns to `ST_IDLE`.
- `ST_REJECT` returns to `ST_IDLE`.

Top module: `ctx_tlb_flush`

## Requirements
- R1: After reset all entries are invalid, `ready` is high, and `inv_busy`, `inv_done`, `inv_fail` and `rsp_valid` are low.
- R2: A lookup accepted on a clock edge (`lk_valid` and `ready`) gives `rsp_valid` high after that edge. `rsp_hit` is high only if a valid entry matches VPN, ASID, PCID and root tag all at once, and in that case `rsp_pfn` holds that entry's frame number.
- R3: A fill accepted with `ready` high chooses its slot in this order of preference: it overwrites an entry with identical VPN, ASID, PCID and root tag; otherwise it takes the lowest-index invalid entry; otherwise it takes a round-robin victim. The victim pointer starts at entry 0 and advances only on an eviction.
- R4: A command is accepted on an edge with `inv_valid` and `ready` high. With `inv_long_mode` high the type is all 64 bits of `inv_kind`. With it low the type is `inv_kind[31:0]`, and bits 63:32 are ignored.
- R5: Type 1 is supported when `inv_cap[0]` is 1. It clears every valid entry whose root tag equals `inv_desc[51:12]`, whatever its ASID and PCID, and keeps entries with other root tags.
- R6: Type 2 is supported when `inv_cap[1]` is 1. It clears all entries.
- R7: A command fails if its type is neither a supported 1 nor a supported 2, or if `inv_desc[127:64]` is non-zero. On failure `inv_fail` pulses for exactly the cycle after acceptance, `inv_done` stays low, no entry changes, and `ready` is high again one cycle later.
- R8: An accepted command visits entries 0 to N-1, one per cycle, clearing at most one entry per cycle. `inv_done` pulses for one cycle in the (N+1)th cycle after acceptance (the 17th with 16 entries), and `ready` returns in the cycle after that.
- R9: While `inv_busy` is high, `ready` is low. Lookups then produce no response, and fills are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_pcid | input | PCID_W | Lookup process-context ID |
| lk_root | input | ROOT_W | Lookup root tag |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_asid | input | ASID_W | Fill address-space ID |
| fill_pcid | input | PCID_W | Fill process-context ID |
| fill_root | input | ROOT_W | Fill root tag |
| fill_pfn | input | PFN_W | Fill frame number |
| ready | output | 1 | Lookups, fills and commands accepted |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on hit, zero on miss |
| inv_valid | input | 1 | Invalidation command request |
| inv_kind | input | KIND_W | Invalidation type value |
| inv_long_mode | input | 1 | Use all 64 type bits (else low 32) |
| inv_desc | input | DESC_W | Invalidation descriptor |
| inv_cap | input | 2 | Supported types: bit 0 type 1, bit 1 type 2 |
| inv_busy | output | 1 | Command in progress |
| inv_done | output | 1 | One-cycle sweep completion pulse |
| inv_fail | output | 1 | One-cycle rejection pulse |

## Verification
A lookup response is registered, so the bench drives a request at a falling edge and samples `rsp_*` at the next falling edge, one rising edge later. For a command, the bench samples `inv_fail` or `inv_busy` at the first falling edge after acceptance. It then counts falling edges and requires `inv_done` to be low for the next 15 and high on the 16th, which is the 17th cycle after acceptance. `ready` must be high one falling edge later. During a sweep, `ready` and `rsp_valid` are checked at every falling edge, and the stalled fill is probed with a lookup after `ready` returns.

// File: rtl/ctxtlb_pkg.sv
package ctxtlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_DONE   = 2'd2,
        ST_REJECT = 2'd3
    } sweep_state_e;

    localparam int unsigned KIND_SINGLE    = 1;
    localparam int unsigned KIND_GLOBAL    = 2;
    localparam int unsigned CAP_W          = 2;
    localparam int unsigned CAP_SINGLE_BIT = 0;
    localparam int unsigned CAP_GLOBAL_BIT = 1;

endpackage

// File: rtl/ctxtlb_cmd_check.sv
module ctxtlb_cmd_check
    import ctxtlb_pkg::*;
#(
    parameter int unsigned KIND_W   = 64,
    parameter int unsigned DESC_W   = 128,
    parameter int unsigned ROOT_W   = 40,
    parameter int unsigned ROOT_LSB = 12
) (
    input  logic [KIND_W-1:0] kind_raw,
    input  logic              long_mode,
    input  logic [DESC_W-1:0] desc,
    input  logic [CAP_W-1:0]  cap,
    output logic              cmd_ok,
    output logic              cmd_global,
    output logic [ROOT_W-1:0] cmd_root
);

    localparam int unsigned LEGACY_W = KIND_W / 2;
    localparam int unsigned PTR_W    = DESC_W / 2;
    localparam int unsigned RSVD_W   = DESC_W - PTR_W;

    logic [KIND_W-1:0] kind_eff;
    logic              want_single;
    logic              want_global;
    logic              rsvd_clear;

    always_comb begin
        if (long_mode) begin
            kind_eff = kind_raw;
        end else begin
            kind_eff = {{(KIND_W-LEGACY_W){1'b0}}, kind_raw[LEGACY_W-1:0]};
        end
        want_single = (kind_eff == KIND_W'(KIND_SINGLE)) && cap[CAP_SINGLE_BIT];
        want_global = (kind_eff == KIND_W'(KIND_GLOBAL)) && cap[CAP_GLOBAL_BIT];
        rsvd_clear  = (desc[PTR_W +: RSVD_W] == '0);
        cmd_ok      = (want_single || want_global) && rsvd_clear;
        cmd_global  = want_global;
        cmd_root    = desc[ROOT_LSB +: ROOT_W];
    end

endmodule

// File: rtl/ctxtlb_entry_array.sv
module ctxtlb_entry_array #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PFN_W       = 20,
    parameter int unsigned ASID_W      = 12,
    parameter int unsigned PCID_W      = 12,
    parameter int unsigned ROOT_W      = 40
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [VPN_W-1:0]               lk_vpn,
    input  logic [ASID_W-1:0]              lk_asid,
    input  logic [PCID_W-1:0]              lk_pcid,
    input  logic [ROOT_W-1:0]              lk_root,
    output logic                           lk_hit,
    output logic [PFN_W-1:0]               lk_pfn,
    input  logic                           fill_en,
    input  logic [VPN_W-1:0]               fill_vpn,
    input  logic [ASID_W-1:0]              fill_asid,
    input  logic [PCID_W-1:0]              fill_pcid,
    input  logic [ROOT_W-1:0]              fill_root,
    input  logic [PFN_W-1:0]               fill_pfn,
    input  logic                           clr_en,
    input  logic [$clog2(NUM_ENTRIES)-1:0] clr_idx,
    input  logic                           clr_global,
    input  logic [ROOT_W-1:0]              clr_root
);

    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_ENTRIES - 1);

    logic              vld_q   [NUM_ENTRIES];
    logic [VPN_W-1:0]  vpn_q   [NUM_ENTRIES];
    logic [PFN_W-1:0]  pfn_q   [NUM_ENTRIES];
    logic [ASID_W-1:0] asid_q  [NUM_ENTRIES];
    logic [PCID_W-1:0] pcid_q  [NUM_ENTRIES];
    logic [ROOT_W-1:0] root_q  [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] lk_match;
    logic [NUM_ENTRIES-1:0] fl_match;
    logic [NUM_ENTRIES-1:0] free_vec;
    logic [IDX_W-1:0]       victim_q;
    logic [IDX_W-1:0]       alloc_idx;
    logic                   need_evict;

    generate
        for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
            localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
            logic sweep_hit;

            assign lk_match[i] = vld_q[i] && (vpn_q[i] == lk_vpn) &&
                                 (asid_q[i] == lk_asid) && (pcid_q[i] == lk_pcid) &&
                                 (root_q[i] == lk_root);
            assign fl_match[i] = vld_q[i] && (vpn_q[i] == fill_vpn) &&
                                 (asid_q[i] == fill_asid) && (pcid_q[i] == fill_pcid) &&
                                 (root_q[i] == fill_root);
            assign free_vec[i] = !vld_q[i];
            assign sweep_hit   = clr_en && (clr_idx == SLOT) &&
                                 (clr_global || (root_q[i] == clr_root));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[i] <= 1'b0;
                end else if (fill_en && (alloc_idx == SLOT)) begin
                    vld_q[i] <= 1'b1;
                end else if (sweep_hit) begin
                    vld_q[i] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (fill_en && (alloc_idx == SLOT)) begin
                    vpn_q[i]  <= fill_vpn;
                    pfn_q[i]  <= fill_pfn;
                    asid_q[i] <= fill_asid;
                    pcid_q[i] <= fill_pcid;
                    root_q[i] <= fill_root;
                end
            end
        end
    endgenerate

    always_comb begin
        lk_hit = |lk_match;
        lk_pfn = '0;
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (lk_match[k]) begin
                lk_pfn = lk_pfn | pfn_q[k];
            end
        end
    end

    always_comb begin
        alloc_idx  = victim_q;
        need_evict = 1'b0;
        if (|fl_match) begin
            for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
                if (fl_match[k]) begin
                    alloc_idx = IDX_W'(k);
                end
            end
        end else if (|free_vec) begin
            for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
                if (free_vec[k]) begin
                    alloc_idx = IDX_W'(k);
                end
            end
        end else begin
            need_evict = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (fill_en && need_evict) begin
            victim_q <= (victim_q == LAST_SLOT) ? '0 : victim_q + 1'b1;
        end
    end

endmodule

// File: rtl/ctx_tlb_flush.sv
module ctx_tlb_flush
    import ctxtlb_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PFN_W       = 20,
    parameter int unsigned ASID_W      = 12,
    parameter int unsigned PCID_W      = 12,
    parameter int unsigned ROOT_W      = 40,
    parameter int unsigned ROOT_LSB    = 12,
    parameter int unsigned KIND_W      = 64,
    parameter int unsigned DESC_W      = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PCID_W-1:0] lk_pcid,
    input  logic [ROOT_W-1:0] lk_root,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PCID_W-1:0] fill_pcid,
    input  logic [ROOT_W-1:0] fill_root,
    input  logic [PFN_W-1:0]  fill_pfn,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    input  logic              inv_valid,
    input  logic [KIND_W-1:0] inv_kind,
    input  logic              inv_long_mode,
    input  logic [DESC_W-1:0] inv_desc,
    input  logic [CAP_W-1:0]  inv_cap,
    output logic              inv_busy,
    output logic              inv_done,
    output logic              inv_fail
);

    localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    sweep_state_e      state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              glob_q;
    logic [ROOT_W-1:0] root_q;

    logic              cmd_ok;
    logic              cmd_global;
    logic [ROOT_W-1:0] cmd_root;
    logic              arr_hit;
    logic [PFN_W-1:0]  arr_pfn;
    logic              accept_cmd;
    logic              sweep_en;

    ctxtlb_cmd_check #(
        .KIND_W   (KIND_W),
        .DESC_W   (DESC_W),
        .ROOT_W   (ROOT_W),
        .ROOT_LSB (ROOT_LSB)
    ) u_check (
        .kind_raw   (inv_kind),
        .long_mode  (inv_long_mode),
        .desc       (inv_desc),
        .cap        (inv_cap),
        .cmd_ok     (cmd_ok),
        .cmd_global (cmd_global),
        .cmd_root   (cmd_root)
    );

    ctxtlb_entry_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .VPN_W       (VPN_W),
        .PFN_W       (PFN_W),
        .ASID_W      (ASID_W),
        .PCID_W      (PCID_W),
        .ROOT_W      (ROOT_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .lk_asid    (lk_asid),
        .lk_pcid    (lk_pcid),
        .lk_root    (lk_root),
        .lk_hit     (arr_hit),
        .lk_pfn     (arr_pfn),
        .fill_en    (fill_valid && ready),
        .fill_vpn   (fill_vpn),
        .fill_asid  (fill_asid),
        .fill_pcid  (fill_pcid),
        .fill_root  (fill_root),
        .fill_pfn   (fill_pfn),
        .clr_en     (sweep_en),
        .clr_idx    (idx_q),
        .clr_global (glob_q),
        .clr_root   (root_q)
    );

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        accept_cmd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_valid) begin
                    accept_cmd = cmd_ok;
                    state_d    = cmd_ok ? ST_SWEEP : ST_REJECT;
                end
            end
            ST_SWEEP: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sweep context: index, latched command kind and root tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            glob_q <= 1'b0;
            root_q <= '0;
        end else if (accept_cmd) begin
            idx_q  <= '0;
            glob_q <= cmd_global;
            root_q <= cmd_root;
        end else if (sweep_en) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready    = 1'b0;
        inv_busy = 1'b1;
        inv_done = 1'b0;
        inv_fail = 1'b0;
        sweep_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready    = 1'b1;
                inv_busy = 1'b0;
            end
            ST_SWEEP:  sweep_en = 1'b1;
            ST_DONE:   inv_done = 1'b1;
            ST_REJECT: inv_fail = 1'b1;
            default:   inv_busy = 1'b1;
        endcase
    end

    // Registered lookup response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
        end else begin
            rsp_valid <= lk_valid && ready;
            rsp_hit   <= lk_valid && ready && arr_hit;
            rsp_pfn   <= (lk_valid && ready && arr_hit) ? arr_pfn : '0;
        end
    end

endmodule

// File: rtl/ctxtlb_checker.sv
module ctxtlb_checker #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic inv_busy,
    input logic inv_done,
    input logic inv_fail
);

    localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (inv_busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R2
    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ready) |=> rsp_valid); // R2
    AST_FAIL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_fail |=> (!inv_fail && ready)); // R7
    AST_FAIL_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_fail |-> (busy_cnt == '0 && !inv_done)); // R7
    AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> (busy_cnt == CNT_W'(NUM_ENTRIES))); // R8
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> (!inv_done && ready)); // R8
    AST_NO_RESP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |=> !rsp_valid); // R9

endmodule

bind ctx_tlb_flush ctxtlb_checker #(
    .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .ready     (ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .inv_busy  (inv_busy),
    .inv_done  (inv_done),
    .inv_fail  (inv_fail)
);

// File: tb/ctx_tlb_flush_bench.sv
module ctx_tlb_flush_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [39:0] RA = 40'h12_3456_789A;
    localparam logic [39:0] RB = 40'hAB_CDEF_0123;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [19:0]  lk_vpn = '0;
    logic [11:0]  lk_asid = '0;
    logic [11:0]  lk_pcid = '0;
    logic [39:0]  lk_root = '0;
    logic         fill_valid = 1'b0;
    logic [19:0]  fill_vpn = '0;
    logic [11:0]  fill_asid = '0;
    logic [11:0]  fill_pcid = '0;
    logic [39:0]  fill_root = '0;
    logic [19:0]  fill_pfn = '0;
    logic         ready;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [19:0]  rsp_pfn;
    logic         inv_valid = 1'b0;
    logic [63:0]  inv_kind = '0;
    logic         inv_long_mode = 1'b0;
    logic [127:0] inv_desc = '0;
    logic [1:0]   inv_cap = '0;
    logic         inv_busy;
    logic         inv_done;
    logic         inv_fail;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_tlb_flush u_ctx_tlb_flush (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_pcid(lk_pcid), .lk_root(lk_root),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pcid(fill_pcid),
        .fill_root(fill_root), .fill_pfn(fill_pfn),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_long_mode(inv_long_mode),
        .inv_desc(inv_desc), .inv_cap(inv_cap),
        .inv_busy(inv_busy), .inv_done(inv_done), .inv_fail(inv_fail)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_desc(input logic [39:0] root, input logic [63:0] rsvd);
        return {rsvd, 12'hFA5, root, 12'h3C7};
    endfunction

    task automatic do_fill(input logic [19:0] vpn, input logic [11:0] asid, input logic [11:0] pcid,
                           input logic [39:0] root, input logic [19:0] pfn);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_pcid = pcid; fill_root = root; fill_pfn = pfn;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_look(input logic [19:0] vpn, input logic [11:0] asid, input logic [11:0] pcid,
                           input logic [39:0] root, input logic exp_hit, input logic [19:0] exp_pfn,
                           input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid; lk_pcid = pcid; lk_root = root;
        @(negedge clk);
        lk_valid = 1'b0;
        check_eq(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check_eq(req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
        if (exp_hit) check_eq(req, "rsp_pfn", 64'(rsp_pfn), 64'(exp_pfn));
    endtask

    task automatic do_inv(input logic [63:0] kind, input logic long_m, input logic [127:0] desc,
                          input logic [1:0] cap, input logic exp_fail, input string req);
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = kind; inv_long_mode = long_m; inv_desc = desc; inv_cap = cap;
        @(negedge clk);
        inv_valid = 1'b0;
        if (exp_fail) begin
            check_eq(req, "inv_fail pulse", 64'(inv_fail), 64'd1);
            check_eq(req, "inv_done on fail", 64'(inv_done), 64'd0);
            @(negedge clk);
            check_eq(req, "inv_fail cleared", 64'(inv_fail), 64'd0);
            check_eq(req, "ready after fail", 64'(ready), 64'd1);
        end else begin
            check_eq(req, "inv_busy start", 64'(inv_busy), 64'd1);
            check_eq(req, "inv_fail on accept", 64'(inv_fail), 64'd0);
            begin
                int early = 0;
                for (int i = 1; i < 16; i++) begin
                    @(negedge clk);
                    if (inv_done) early++;
                end
                check_eq("R8", "early done count", 64'(early), 64'd0);
            end
            @(negedge clk);
            check_eq("R8", "done in 17th cycle", 64'(inv_done), 64'd1);
            @(negedge clk);
            check_eq("R8", "done single pulse", 64'(inv_done), 64'd0);
            check_eq("R8", "ready after done", 64'(ready), 64'd1);
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "ready", 64'(ready), 64'd1);
        check_eq("R1", "inv_busy", 64'(inv_busy), 64'd0);
        check_eq("R1", "inv_done", 64'(inv_done), 64'd0);
        check_eq("R1", "inv_fail", 64'(inv_fail), 64'd0);
        check_eq("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        do_look(20'h0, 12'h0, 12'h0, 40'h0, 1'b0, 20'h0, "R1");
    endtask

    task automatic t_lookup_basic();
        do_fill(20'h00A1, 12'h001, 12'h001, RA, 20'h11111);
        do_look(20'h00A1, 12'h001, 12'h001, RA, 1'b1, 20'h11111, "R2");
        do_look(20'h00A1, 12'h002, 12'h001, RA, 1'b0, 20'h0, "R2");
        do_look(20'h00A1, 12'h001, 12'h009, RA, 1'b0, 20'h0, "R2");
        do_look(20'h00A1, 12'h001, 12'h001, RB, 1'b0, 20'h0, "R2");
    endtask

    task automatic t_fill_overwrite();
        do_fill(20'h00A1, 12'h001, 12'h001, RA, 20'h22222);
        do_look(20'h00A1, 12'h001, 12'h001, RA, 1'b1, 20'h22222, "R3");
    endtask

    task automatic t_single_ctx();
        do_fill(20'h00B2, 12'h002, 12'h005, RA, 20'h33333);
        do_fill(20'h00C3, 12'h001, 12'h001, RB, 20'h44444);
        do_inv(64'd1, 1'b1, mk_desc(RA, 64'h0), 2'b11, 1'b0, "R5");
        do_look(20'h00A1, 12'h001, 12'h001, RA, 1'b0, 20'h0, "R5");
        do_look(20'h00B2, 12'h002, 12'h005, RA, 1'b0, 20'h0, "R5");
        do_look(20'h00C3, 12'h001, 12'h001, RB, 1'b1, 20'h44444, "R5");
    endtask

    task automatic t_fail_cases();
        do_inv(64'd3, 1'b1, mk_desc(RB, 64'h0), 2'b11, 1'b1, "R7");
        do_look(20'h00C3, 12'h001, 12'h001, RB, 1'b1, 20'h44444, "R7");
        do_inv(64'd2, 1'b1, mk_desc(RB, 64'h0), 2'b01, 1'b1, "R7");
        do_inv(64'd1, 1'b1, mk_desc(RB, 64'h0), 2'b10, 1'b1, "R7");
        do_inv(64'd1, 1'b1, mk_desc(RB, 64'h8000_0000_0000_0000), 2'b11, 1'b1, "R7");
        do_look(20'h00C3, 12'h001, 12'h001, RB, 1'b1, 20'h44444, "R7");
    endtask

    task automatic t_mode_width();
        do_inv(64'h1_0000_0002, 1'b1, mk_desc(RA, 64'h0), 2'b11, 1'b1, "R4");
        do_look(20'h00C3, 12'h001, 12'h001, RB, 1'b1, 20'h44444, "R4");
        do_inv(64'h1_0000_0002, 1'b0, mk_desc(RA, 64'h0), 2'b11, 1'b0, "R4");
        do_look(20'h00C3, 12'h001, 12'h001, RB, 1'b0, 20'h0, "R6");
    endtask

    task automatic t_evict();
        for (int v = 0; v < 16; v++) begin
            do_fill(20'(v), 12'h001, 12'h001, RA, 20'(v + 32'h500));
        end
        do_fill(20'h0100, 12'h001, 12'h001, RA, 20'h77777);
        do_look(20'h0000, 12'h001, 12'h001, RA, 1'b0, 20'h0, "R3");
        do_look(20'h0001, 12'h001, 12'h001, RA, 1'b1, 20'h00501, "R3");
        do_look(20'h0100, 12'h001, 12'h001, RA, 1'b1, 20'h77777, "R3");
    endtask

    task automatic t_busy_block();
        int stray_rsp = 0;
        int ready_high = 0;
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = 64'd2; inv_long_mode = 1'b1;
        inv_desc = mk_desc(RB, 64'h0); inv_cap = 2'b10;
        @(negedge clk);
        inv_valid = 1'b0;
        lk_valid = 1'b1; lk_vpn = 20'h0001; lk_asid = 12'h001; lk_pcid = 12'h001; lk_root = RA;
        fill_valid = 1'b1; fill_vpn = 20'h0200; fill_asid = 12'h001; fill_pcid = 12'h001;
        fill_root = RB; fill_pfn = 20'h99999;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (rsp_valid) stray_rsp++;
            if (ready) ready_high++;
        end
        check_eq("R8", "done at end of busy sweep", 64'(inv_done), 64'd1);
        lk_valid = 1'b0;
        fill_valid = 1'b0;
        check_eq("R9", "responses while busy", 64'(stray_rsp), 64'd0);
        check_eq("R9", "ready while busy", 64'(ready_high), 64'd0);
        @(negedge clk);
        check_eq("R9", "ready after sweep", 64'(ready), 64'd1);
        do_look(20'h0200, 12'h001, 12'h001, RB, 1'b0, 20'h0, "R9");
        do_look(20'h0001, 12'h001, 12'h001, RA, 1'b0, 20'h0, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lookup_basic();
        t_fill_overwrite();
        t_single_ctx();
        t_fail_cases();
        t_mode_width();
        t_evict();
        t_busy_block();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule